// File: doc/BRIEF.md
# Effective Address Generator

This block turns a decoded addressing mode and the bytes that follow an opcode into the address an 8-bit accumulator machine needs next. It works in a 16-bit address space. Each request carries five things: the mode, the first and second bytes after the opcode, the address and length of the current instruction, and both 16-bit index registers. A select input, set by the decoder when a prefix byte chose the second index register, decides which index register is used. One cycle after a request, the block presents the result. For memory modes the result is the operand address. For relative mode it is the branch target. For immediate mode it is the immediate data itself, flagged as such.

One three-input adder serves every mode. It sums a base, an offset and an increment, and the result wraps modulo 2^16. Direct addresses are confined to page zero. Index offsets are zero-extended. Relative offsets are sign-extended and added to the address that follows the instruction, which is the instruction address plus its length. Instruction fetch and the memory access itself belong to other blocks.

Top module: `eag_top`

## Requirements
- R1: `res_vld` is high exactly one cycle after a cycle with `req_vld` high and low otherwise; while no request arrives, `res_addr`, `res_imm` and `res_mem` keep their last values.
- R2: During and after reset, until the first request, `res_vld`, `res_imm` and `res_mem` are 0 and `res_addr` is 0x0000.
- R3: Mode code 1 (immediate) gives `res_imm`=1 and `res_mem`=0. `res_addr` is {`arg_hi`,`arg_lo`} when `imm16` is 1, else {0x00,`arg_hi`}.
- R4: Mode code 2 (page-zero) gives `res_addr` = {0x00,`arg_hi`}, so the upper byte is always zero, with `res_mem`=1.
- R5: Mode code 3 (absolute) gives `res_addr` = {`arg_hi`,`arg_lo`}, the first byte after the opcode being the high byte, with `res_mem`=1.
- R6: Mode code 4 (indexed) with `sel_y`=0 gives `res_addr` = `ix` + zero-extended `arg_hi`, modulo 2^16, with `res_mem`=1.
- R7: In mode code 4, `sel_y`=1 uses `iy` in place of `ix`; outside mode 4, `sel_y` changes nothing.
- R8: Mode code 5 (relative) gives `res_addr` = `ins_pc` + `ins_len` + sign-extended `arg_hi`, modulo 2^16, with `res_mem`=0 and `res_imm`=0; a 2-byte branch with offset 0xF0 lands 16 bytes before the address after the branch.
- R9: Mode code 0 (no operand) and the unused codes 6 and 7 give `res_addr`=0x0000, `res_imm`=0 and `res_mem`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_vld | input | 1 | Request strobe; the inputs below are taken in this cycle |
| mode | input | 3 | Addressing mode code (0 none, 1 immediate, 2 page-zero, 3 absolute, 4 indexed, 5 relative) |
| arg_hi | input | 8 | First byte after the opcode |
| arg_lo | input | 8 | Second byte after the opcode |
| imm16 | input | 1 | Immediate operand is two bytes wide |
| sel_y | input | 1 | Use the second index register (prefix seen) |
| ins_pc | input | 16 | Address of the first byte of the instruction |
| ins_len | input | 3 | Instruction length in bytes, prefix included |
| ix | input | 16 | First index register |
| iy | input | 16 | Second index register |
| res_vld | output | 1 | Result valid |
| res_addr | output | 16 | Effective address, branch target or immediate data |
| res_imm | output | 1 | Result is immediate data |
| res_mem | output | 1 | Result addresses a memory operand |

## Verification
The bench builds the block with its default widths: a 16-bit address, 8-bit bytes and a 3-bit length. At that size the corners that matter can be driven directly. Indexed sums and relative targets carry out of bit 15 and wrap. Backward branches cross below 0x0000. Full-width extended and immediate values reach 0xFFFF. Requests are also issued back to back and separated by idle gaps, so both the one-cycle latency and the hold behaviour are exercised.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [2:0] {
    EAM_NONE = 3'd0,
    EAM_IMM  = 3'd1,
    EAM_PG0  = 3'd2,
    EAM_ABS  = 3'd3,
    EAM_IDX  = 3'd4,
    EAM_REL  = 3'd5
  } eam_e;

endpackage

// File: rtl/eag_rst_sync.sv
module eag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/eag_operand.sv
module eag_operand
  import eag_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic [2:0]    mode,
  input  logic [DW-1:0] arg_hi,
  input  logic [DW-1:0] arg_lo,
  input  logic          imm16,
  input  logic          sel_y,
  input  logic [AW-1:0] ins_pc,
  input  logic [LW-1:0] ins_len,
  input  logic [AW-1:0] ix,
  input  logic [AW-1:0] iy,
  output logic [AW-1:0] term_a,
  output logic [AW-1:0] term_b,
  output logic [AW-1:0] term_c,
  output logic          is_imm,
  output logic          is_mem
);

  localparam int EXT = AW - DW;

  logic [AW-1:0] ofs_zx;
  logic [AW-1:0] ofs_sx;
  logic [AW-1:0] pair;
  logic [AW-1:0] len_zx;
  logic [AW-1:0] idx_sel;

  assign ofs_zx[DW-1:0] = arg_hi;
  assign ofs_sx[DW-1:0] = arg_hi;

  generate
    for (genvar g = DW; g < AW; g++) begin : g_ext
      assign ofs_zx[g] = 1'b0;
      assign ofs_sx[g] = arg_hi[DW-1];
    end
    if (AW >= 2 * DW) begin : g_pair_wide
      assign pair = {{(AW - 2 * DW){1'b0}}, arg_hi, arg_lo};
    end else begin : g_pair_narrow
      logic [2*DW-1:0] full;
      assign full = {arg_hi, arg_lo};
      assign pair = full[AW-1:0];
    end
  endgenerate

  assign len_zx  = {{(AW - LW){1'b0}}, ins_len};
  assign idx_sel = sel_y ? iy : ix;

  always_comb begin
    term_a = '0;
    term_b = '0;
    term_c = '0;
    is_imm = 1'b0;
    is_mem = 1'b0;
    case (mode)
      EAM_IMM: begin
        is_imm = 1'b1;
        term_a = imm16 ? pair : ofs_zx;
      end
      EAM_PG0: begin
        is_mem = 1'b1;
        term_a = ofs_zx;
      end
      EAM_ABS: begin
        is_mem = 1'b1;
        term_a = pair;
      end
      EAM_IDX: begin
        is_mem = 1'b1;
        term_a = idx_sel;
        term_b = ofs_zx;
      end
      EAM_REL: begin
        term_a = ins_pc;
        term_b = ofs_sx;
        term_c = len_zx;
      end
      default: begin
        term_a = '0;
      end
    endcase
  end

  initial begin
    AST_WIDTH_OK: assert (EXT >= 0 && AW > LW) else $error("bad widths");
  end

endmodule

// File: rtl/eag_adder.sv
module eag_adder #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  input  logic [AW-1:0] c,
  output logic [AW-1:0] sum
);

  logic [AW-1:0] ab;

  always_comb begin
    ab  = a + b;
    sum = ab + c;
  end

endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_vld,
  input  logic [2:0]    mode,
  input  logic [DW-1:0] arg_hi,
  input  logic [DW-1:0] arg_lo,
  input  logic          imm16,
  input  logic          sel_y,
  input  logic [AW-1:0] ins_pc,
  input  logic [LW-1:0] ins_len,
  input  logic [AW-1:0] ix,
  input  logic [AW-1:0] iy,
  output logic          res_vld,
  output logic [AW-1:0] res_addr,
  output logic          res_imm,
  output logic          res_mem
);

  localparam int HI = AW - DW;

  logic          rst_q_n;
  logic [AW-1:0] t_a, t_b, t_c, sum;
  logic          op_imm, op_mem;

  logic          vld_q, vld_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          imm_q, imm_d;
  logic          mem_q, mem_d;

  eag_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  eag_operand #(.AW(AW), .DW(DW), .LW(LW)) u_opnd (
    .mode    (mode),
    .arg_hi  (arg_hi),
    .arg_lo  (arg_lo),
    .imm16   (imm16),
    .sel_y   (sel_y),
    .ins_pc  (ins_pc),
    .ins_len (ins_len),
    .ix      (ix),
    .iy      (iy),
    .term_a  (t_a),
    .term_b  (t_b),
    .term_c  (t_c),
    .is_imm  (op_imm),
    .is_mem  (op_mem)
  );

  eag_adder #(.AW(AW)) u_add (
    .a   (t_a),
    .b   (t_b),
    .c   (t_c),
    .sum (sum)
  );

  always_comb begin
    vld_d  = req_vld;
    addr_d = addr_q;
    imm_d  = imm_q;
    mem_d  = mem_q;
    if (req_vld) begin
      addr_d = sum;
      imm_d  = op_imm;
      mem_d  = op_mem;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      imm_q  <= 1'b0;
      mem_q  <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      addr_q <= addr_d;
      imm_q  <= imm_d;
      mem_q  <= mem_d;
    end
  end

  assign res_vld  = vld_q;
  assign res_addr = addr_q;
  assign res_imm  = imm_q;
  assign res_mem  = mem_q;

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_vld |=> res_vld); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req_vld |=> (!res_vld && $stable(res_addr) && $stable(res_imm) && $stable(res_mem))); // R1
  AST_IMM_FLAG: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_vld && mode == 3'd1) |=> (res_imm && !res_mem)); // R3
  AST_PG0_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_vld && mode == 3'd2) |=> (res_addr[AW-1:DW] == {HI{1'b0}} && res_mem)); // R4
  AST_ABS_PAIR: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_vld && mode == 3'd3) |=> (res_addr[DW-1:0] == $past(arg_lo) && res_mem && !res_imm)); // R5
  AST_REL_NO_MEM: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_vld && mode == 3'd5) |=> (!res_mem && !res_imm)); // R8
  AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_vld && (mode == 3'd0 || mode > 3'd5)) |=> (res_addr == '0 && !res_mem && !res_imm)); // R9

endmodule

// File: tb/sim_eag_top.sv
module sim_eag_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld;
  logic [2:0]  mode;
  logic [7:0]  arg_hi, arg_lo;
  logic        imm16, sel_y;
  logic [15:0] ins_pc;
  logic [2:0]  ins_len;
  logic [15:0] ix, iy;
  logic        res_vld;
  logic [15:0] res_addr;
  logic        res_imm, res_mem;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [15:0] addr;
    bit          imm;
    bit          mem;
    string       tag;
  } exp_t;

  exp_t sb[$];
  logic [15:0] last_addr;
  bit          last_imm, last_mem;

  always #5 clk = ~clk;

  eag_top u0 (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .mode(mode),
    .arg_hi(arg_hi), .arg_lo(arg_lo), .imm16(imm16), .sel_y(sel_y),
    .ins_pc(ins_pc), .ins_len(ins_len), .ix(ix), .iy(iy),
    .res_vld(res_vld), .res_addr(res_addr), .res_imm(res_imm), .res_mem(res_mem)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] m, input logic [7:0] h, input logic [7:0] l,
                       input bit w, input bit y, input logic [15:0] pc,
                       input logic [2:0] len, input string tag);
    exp_t e;
    e.imm = 0; e.mem = 0; e.addr = 16'h0000; e.tag = tag;
    case (m)
      3'd1: begin e.imm = 1; e.addr = w ? {h, l} : {8'h00, h}; end
      3'd2: begin e.mem = 1; e.addr = {8'h00, h}; end
      3'd3: begin e.mem = 1; e.addr = {h, l}; end
      3'd4: begin e.mem = 1; e.addr = (y ? iy : ix) + {8'h00, h}; end
      3'd5: e.addr = pc + {13'd0, len} + {{8{h[7]}}, h};
      default: e.addr = 16'h0000;
    endcase
    mode = m; arg_hi = h; arg_lo = l; imm16 = w; sel_y = y;
    ins_pc = pc; ins_len = len; req_vld = 1'b1;
    sb.push_back(e);
    last_addr = e.addr; last_imm = e.imm; last_mem = e.mem;
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (res_vld) begin
        if (sb.size() == 0) begin
          check(0, "R1", "unexpected valid", {15'd0, res_vld}, 16'h0000);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(res_addr == e.addr, e.tag, "addr", res_addr, e.addr);
          check(res_imm == e.imm && res_mem == e.mem, e.tag, "imm/mem flags",
                {14'd0, res_imm, res_mem}, {14'd0, e.imm, e.mem});
        end
      end
    end
  end

  task automatic idle_check(input int n);
    repeat (n) @(negedge clk);
    check(!res_vld && res_addr == last_addr && res_imm == last_imm && res_mem == last_mem,
          "R1", "hold while idle", res_addr, last_addr);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0; req_vld = 1'b0; mode = 3'd0; arg_hi = 8'h00; arg_lo = 8'h00;
    imm16 = 1'b0; sel_y = 1'b0; ins_pc = 16'h0000; ins_len = 3'd0;
    ix = 16'h1234; iy = 16'hABCD;
    repeat (3) @(negedge clk);
    check(!res_vld && res_addr == 16'h0000 && !res_imm && !res_mem, "R2", "in reset",
          res_addr, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!res_vld && res_addr == 16'h0000 && !res_imm && !res_mem, "R2", "after release",
          res_addr, 16'h0000);

    issue(3'd1, 8'h4A, 8'h77, 0, 0, 16'hC000, 3'd2, "R3");
    issue(3'd1, 8'hFF, 8'hFF, 1, 0, 16'hC002, 3'd3, "R3");
    issue(3'd2, 8'h1B, 8'hEE, 0, 0, 16'hC005, 3'd2, "R4");
    issue(3'd2, 8'hFF, 8'h00, 0, 1, 16'hC007, 3'd2, "R4");
    idle_check(3);
    issue(3'd3, 8'h6D, 8'h00, 0, 0, 16'hC009, 3'd3, "R5");
    issue(3'd3, 8'hFF, 8'hFF, 0, 1, 16'hC00C, 3'd3, "R5");
    issue(3'd4, 8'h56, 8'h00, 0, 0, 16'hC00F, 3'd2, "R6");
    ix = 16'hFFF0;
    issue(3'd4, 8'h20, 8'h00, 0, 0, 16'hC011, 3'd2, "R6");
    issue(3'd4, 8'hF0, 8'h00, 0, 0, 16'hC013, 3'd2, "R6");
    idle_check(2);
    issue(3'd4, 8'h56, 8'h00, 0, 1, 16'hC015, 3'd3, "R7");
    iy = 16'hFFFF;
    issue(3'd4, 8'h01, 8'h00, 0, 1, 16'hC018, 3'd3, "R7");
    issue(3'd3, 8'h12, 8'h34, 0, 1, 16'hC01B, 3'd4, "R7");
    issue(3'd5, 8'hF0, 8'h00, 0, 0, 16'h0015, 3'd2, "R8");
    issue(3'd5, 8'h10, 8'h00, 0, 0, 16'h2000, 3'd2, "R8");
    issue(3'd5, 8'h80, 8'h00, 0, 0, 16'h0004, 3'd2, "R8");
    issue(3'd5, 8'h7F, 8'h00, 0, 1, 16'hFFF0, 3'd4, "R8");
    idle_check(4);
    issue(3'd0, 8'h55, 8'hAA, 1, 1, 16'h1000, 3'd1, "R9");
    issue(3'd6, 8'h55, 8'hAA, 0, 0, 16'h1001, 3'd1, "R9");
    issue(3'd7, 8'h33, 8'h44, 1, 0, 16'h1002, 3'd1, "R9");
    idle_check(3);
    repeat (2) @(negedge clk);
    check(sb.size() == 0, "R1", "results outstanding", 16'(sb.size()), 16'h0000);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule